// File: doc/BRIEF.md
# Twin-Channel Phase Detector with Status Pin Selector

This block holds the digital half of two frequency synthesizer loops. Each channel compares a stream of single-cycle reference-divider pulses with a stream of single-cycle main-divider pulses. It tracks which stream leads and turns that into charge-pump steering: source, sink or high impedance. The pump direction for a given phase error can be inverted per channel. A per-channel force bit parks the pump in high impedance. A per-channel power-down clears the detector and the lock state. Each channel also qualifies its own lock indication from the width of its phase-error pulses.

A single open-collector status pin is shared by both channels. A two-bit selector and a test bit choose what it carries: a static port bit, the lock of either channel, the OR of both locks, or, in counter test mode, the raw output of one of the four dividers. The pin is registered, so it never glitches. A pin value of 1 means the output transistor is off and the pin is released (high impedance). The analog pump and its current setting are outside this block.

Top module: `twin_pfd_status`

## Requirements
- R1: While `rst` is high and in the cycle after it, every `pump_hiz` bit is 1, `pump_up` and `pump_dn` are 0, `lock` is 0 and `stat_pin` is 1.
- R2: With `pol_norm`=1, a reference pulse sampled ahead of the main pulse drives `pump_dn` (sink) from the cycle after the reference pulse until the main pulse is sampled. A main pulse sampled ahead drives `pump_up` (source) in the same way.
- R3: With `pol_norm`=0, the two cases of R2 swap: a leading reference drives `pump_up`, and a leading main pulse drives `pump_dn`.
- R4: Reference and main pulses sampled in the same cycle drive neither output. Once both leads are recorded, both are cleared at the next edge, with no pump activity.
- R5: `hold_hiz`=1 makes `pump_hiz` 1 and `pump_up`/`pump_dn` 0 in the same cycle, whatever the phase error.
- R6: `chan_pd`=1 forces high impedance and `lock`=0 in the same cycle. It clears any pending lead, so after release no pump activity remains from earlier pulses.
- R7: `lock` rises at the edge that samples the LOCK_REFS-th reference pulse (default 4) counted since reset, power-down or the last clearing. Error pulses of at most LOCK_WIN cycles (default 2) do not disturb it.
- R8: An error pulse that lasts LOCK_WIN+1 cycles clears `lock` and the count at that edge. If a reference pulse is sampled at the same edge, the clearing wins.
- R9: The status pin is registered. One cycle after the inputs are sampled, it shows `port_bit` for selector 00, channel 2 lock for 01, channel 1 lock for 10, and the OR of both locks for 11.
- R10: With `test_en`=1, selector 10 routes channel 1's reference pulse (`pick_ref[0]`=1) or main pulse (`pick_ref[0]`=0) to the pin one cycle later. Selector 01 does the same for channel 2 with `pick_ref[1]`. Selectors 00 and 11 behave as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pls | input | 2 | Reference-divider pulse per channel (bit 0 = channel 1) |
| fb_pls | input | 2 | Main-divider pulse per channel |
| pol_norm | input | 2 | Pump polarity per channel, 1 = normal, 0 = inverted |
| hold_hiz | input | 2 | Force pump to high impedance per channel |
| chan_pd | input | 2 | Power-down per channel, 1 = down |
| lock_sel | input | 2 | Status pin source selector |
| test_en | input | 1 | Counter test mode on the status pin |
| pick_ref | input | 2 | Test mode divider choice per channel, 1 = reference |
| port_bit | input | 1 | Static open-collector port value |
| pump_up | output | 2 | Pump source command per channel |
| pump_dn | output | 2 | Pump sink command per channel |
| pump_hiz | output | 2 | Pump high impedance per channel |
| lock | output | 2 | Lock indication per channel |
| stat_pin | output | 1 | Status pin value, 1 = released |

## Verification
Two events can land on the same edge in the lock qualifier. An error pulse can reach the LOCK_WIN+1 width in the same cycle that a reference pulse would advance the lock count. The bench lets a main pulse lead and places the late reference pulse exactly on the edge where the error becomes too wide. It then expects `lock` low and needs a full LOCK_REFS clean pulses before lock returns. In the phase detector, a new pulse arriving at the edge where both leads clear is covered by the coincident-pulse sweeps. Every check uses expected values from the pulse spacing alone.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int NCH = 2;

    typedef enum logic [1:0] {
        PUMP_HIZ = 2'b00,
        PUMP_SRC = 2'b01,
        PUMP_SNK = 2'b10
    } pump_e;

    typedef enum logic [1:0] {
        SEL_PORT  = 2'b00,
        SEL_LOCK2 = 2'b01,
        SEL_LOCK1 = 2'b10,
        SEL_BOTH  = 2'b11
    } pin_sel_e;

    typedef struct packed {
        logic ref_lead;
        logic fb_lead;
    } phase_t;

    // Steering: a leading reference sinks under normal polarity.
    function automatic pump_e pump_dir(phase_t ph, logic pol, logic off);
        if (off || (ph.ref_lead == ph.fb_lead))
            return PUMP_HIZ;
        if (ph.ref_lead)
            return pol ? PUMP_SNK : PUMP_SRC;
        return pol ? PUMP_SRC : PUMP_SNK;
    endfunction

endpackage

// File: rtl/pfd_phase_flags.sv
module pfd_phase_flags
    import pfd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pd,
    input  logic   ref_pls,
    input  logic   fb_pls,
    output phase_t ph,
    output logic   err
);
    logic fr_q, ff_q;
    logic both;

    assign both = fr_q & ff_q;

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            fr_q <= 1'b0;
            ff_q <= 1'b0;
        end else begin
            fr_q <= (both ? 1'b0 : fr_q) | ref_pls;
            ff_q <= (both ? 1'b0 : ff_q) | fb_pls;
        end
    end

    assign ph.ref_lead = fr_q & ~ff_q;
    assign ph.fb_lead  = ff_q & ~fr_q;
    assign err         = fr_q ^ ff_q;
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
    parameter int WIN  = 2,
    parameter int REFS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pd,
    input  logic ref_pls,
    input  logic err,
    output logic lock
);
    localparam int RW = (WIN < 1) ? 1 : $clog2(WIN + 1);
    localparam int CW = (REFS < 2) ? 1 : $clog2(REFS + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(WIN);
    localparam logic [CW-1:0] CNT_MAX = CW'(REFS);

    logic [RW-1:0] run_q;
    logic [CW-1:0] good_q;
    logic          wide;

    // Error has already lasted WIN cycles and is still present.
    assign wide = err && (run_q >= RUN_MAX);

    always_ff @(posedge clk) begin
        if (rst || pd)
            run_q <= '0;
        else if (!err)
            run_q <= '0;
        else if (run_q != RUN_MAX)
            run_q <= run_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || pd)
            good_q <= '0;
        else if (wide)
            good_q <= '0;
        else if (ref_pls && (good_q != CNT_MAX))
            good_q <= good_q + 1'b1;
    end

    assign lock = (good_q == CNT_MAX) && !pd;
endmodule

// File: rtl/pfd_channel.sv
module pfd_channel
    import pfd_pkg::*;
#(
    parameter int WIN  = 2,
    parameter int REFS = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_pls,
    input  logic  fb_pls,
    input  logic  pol,
    input  logic  hiz_force,
    input  logic  pd,
    output pump_e pump,
    output logic  lock
);
    phase_t ph;
    logic   err;

    pfd_phase_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .pd      (pd),
        .ref_pls (ref_pls),
        .fb_pls  (fb_pls),
        .ph      (ph),
        .err     (err)
    );

    pfd_lock_det #(.WIN(WIN), .REFS(REFS)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .pd      (pd),
        .ref_pls (ref_pls),
        .err     (err),
        .lock    (lock)
    );

    assign pump = pump_dir(ph, pol, hiz_force | pd | rst);
endmodule

// File: rtl/pfd_pin_mux.sv
module pfd_pin_mux
    import pfd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] lock,
    input  logic [NCH-1:0] ref_pls,
    input  logic [NCH-1:0] fb_pls,
    input  logic [NCH-1:0] pick_ref,
    input  logic [1:0]     sel,
    input  logic           test_en,
    input  logic           port_bit,
    output logic           pin
);
    pin_sel_e sel_e;
    logic     nxt;

    assign sel_e = pin_sel_e'(sel);

    always_comb begin
        unique case (sel_e)
            SEL_PORT:  nxt = port_bit;
            SEL_LOCK2: nxt = test_en ? (pick_ref[1] ? ref_pls[1] : fb_pls[1]) : lock[1];
            SEL_LOCK1: nxt = test_en ? (pick_ref[0] ? ref_pls[0] : fb_pls[0]) : lock[0];
            SEL_BOTH:  nxt = lock[0] | lock[1];
            default:   nxt = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pin <= 1'b1;
        else
            pin <= nxt;
    end
endmodule

// File: rtl/twin_pfd_status.sv
module twin_pfd_status
    import pfd_pkg::*;
#(
    parameter int LOCK_WIN  = 2,
    parameter int LOCK_REFS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ref_pls,
    input  logic [1:0] fb_pls,
    input  logic [1:0] pol_norm,
    input  logic [1:0] hold_hiz,
    input  logic [1:0] chan_pd,
    input  logic [1:0] lock_sel,
    input  logic       test_en,
    input  logic [1:0] pick_ref,
    input  logic       port_bit,
    output logic [1:0] pump_up,
    output logic [1:0] pump_dn,
    output logic [1:0] pump_hiz,
    output logic [1:0] lock,
    output logic       stat_pin
);
    pump_e pump [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pfd_channel #(.WIN(LOCK_WIN), .REFS(LOCK_REFS)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .ref_pls   (ref_pls[c]),
            .fb_pls    (fb_pls[c]),
            .pol       (pol_norm[c]),
            .hiz_force (hold_hiz[c]),
            .pd        (chan_pd[c]),
            .pump      (pump[c]),
            .lock      (lock[c])
        );
        assign pump_up[c]  = (pump[c] == PUMP_SRC);
        assign pump_dn[c]  = (pump[c] == PUMP_SNK);
        assign pump_hiz[c] = (pump[c] == PUMP_HIZ);
    end

    pfd_pin_mux u_mux (
        .clk      (clk),
        .rst      (rst),
        .lock     (lock),
        .ref_pls  (ref_pls),
        .fb_pls   (fb_pls),
        .pick_ref (pick_ref),
        .sel      (lock_sel),
        .test_en  (test_en),
        .port_bit (port_bit),
        .pin      (stat_pin)
    );
endmodule

// File: rtl/twin_pfd_status_chk.sv
module twin_pfd_status_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ref_pls,
    input logic [1:0] fb_pls,
    input logic [1:0] pol_norm,
    input logic [1:0] hold_hiz,
    input logic [1:0] chan_pd,
    input logic [1:0] lock_sel,
    input logic       test_en,
    input logic [1:0] pick_ref,
    input logic       port_bit,
    input logic [1:0] pump_up,
    input logic [1:0] pump_dn,
    input logic [1:0] pump_hiz,
    input logic [1:0] lock,
    input logic       stat_pin
);
    for (genvar i = 0; i < 2; i++) begin : g_a
        AST_PUMP_EXCL: assert property (@(posedge clk) disable iff (rst)
            !(pump_up[i] && pump_dn[i]));                                            // R2
        AST_FORCED_HIZ: assert property (@(posedge clk) disable iff (rst)
            hold_hiz[i] |-> (pump_hiz[i] && !pump_up[i] && !pump_dn[i]));           // R5
        AST_PD_HIZ_NOLOCK: assert property (@(posedge clk) disable iff (rst)
            chan_pd[i] |-> (pump_hiz[i] && !lock[i]));                              // R6
        AST_LOCK_RISE_ON_REF: assert property (@(posedge clk) disable iff (rst)
            (lock[i] && !$past(lock[i])) |-> $past(ref_pls[i]));                    // R7
        AST_SNK_FROM_REF: assert property (@(posedge clk) disable iff (rst)
            ($rose(pump_dn[i]) && pol_norm[i] && $past(pol_norm[i]) && $past(!hold_hiz[i]))
                |-> $past(ref_pls[i]));                                             // R2
        AST_SRC_FROM_FB: assert property (@(posedge clk) disable iff (rst)
            ($rose(pump_up[i]) && pol_norm[i] && $past(pol_norm[i]) && $past(!hold_hiz[i]))
                |-> $past(fb_pls[i]));                                              // R2
    end

    AST_PIN_PORT: assert property (@(posedge clk) disable iff (rst)
        (lock_sel == 2'b00) |=> (stat_pin == $past(port_bit)));                     // R9
    AST_PIN_BOTH: assert property (@(posedge clk) disable iff (rst)
        (lock_sel == 2'b11) |=> (stat_pin == $past(lock[0] | lock[1])));            // R9
    AST_TEST_REF1: assert property (@(posedge clk) disable iff (rst)
        (test_en && lock_sel == 2'b10 && pick_ref[0]) |=> (stat_pin == $past(ref_pls[0]))); // R10
    AST_TEST_FB2: assert property (@(posedge clk) disable iff (rst)
        (test_en && lock_sel == 2'b01 && !pick_ref[1]) |=> (stat_pin == $past(fb_pls[1]))); // R10
endmodule

bind twin_pfd_status twin_pfd_status_chk chk_i (.*);

// File: tb/twin_pfd_status_tb_top.sv
`timescale 1ns/1ps
module twin_pfd_status_tb_top;
    localparam int WIN  = 2;
    localparam int REFS = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ref_pls, fb_pls, pol_norm, hold_hiz, chan_pd, lock_sel, pick_ref;
    logic       test_en, port_bit;
    logic [1:0] pump_up, pump_dn, pump_hiz, lock;
    logic       stat_pin;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    twin_pfd_status #(.LOCK_WIN(WIN), .LOCK_REFS(REFS)) dut_i (
        .clk(clk), .rst(rst), .ref_pls(ref_pls), .fb_pls(fb_pls),
        .pol_norm(pol_norm), .hold_hiz(hold_hiz), .chan_pd(chan_pd),
        .lock_sel(lock_sel), .test_en(test_en), .pick_ref(pick_ref),
        .port_bit(port_bit), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_hiz(pump_hiz), .lock(lock), .stat_pin(stat_pin)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        ref_pls = '0; fb_pls = '0;
        for (int k = 0; k < n; k++) tick();
    endtask

    // Coincident pulse pair on channel c, then quiet gap.
    task automatic pair(input int c);
        ref_pls[c] = 1'b1; fb_pls[c] = 1'b1;
        tick();
        ref_pls = '0; fb_pls = '0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #160000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ref_pls = '0; fb_pls = '0; pol_norm = 2'b11; hold_hiz = '0;
        chan_pd = '0; lock_sel = 2'b00; test_en = 1'b0; pick_ref = '0; port_bit = 1'b0;
        tick(); tick();
        chk("R1 hiz in reset", {6'd0, pump_hiz}, 8'd3);
        chk("R1 lock in reset", {6'd0, lock}, 8'd0);
        chk("R1 pin in reset", {7'd0, stat_pin}, 8'd1);
        rst = 1'b0;
        #1;
        chk("R1 pump after reset", {4'd0, pump_up, pump_dn}, 8'd0);
        tick();
        chk("R1 hiz after reset", {6'd0, pump_hiz}, 8'd3);

        // R2 R3 R4 R5: sweep channel, polarity, force, leader, spacing
        for (int c = 0; c < 2; c++)
        for (int p = 0; p < 2; p++)
        for (int h = 0; h < 2; h++)
        for (int lead = 0; lead < 2; lead++)
        for (int d = 1; d <= 4; d++) begin
            logic exp_up, exp_dn;
            pol_norm = '0; hold_hiz = '0;
            pol_norm[c] = p[0]; hold_hiz[c] = h[0];
            exp_dn = !h[0] && ((lead == 0) ? p[0] : !p[0]);
            exp_up = !h[0] && ((lead == 0) ? !p[0] : p[0]);
            if (lead == 0) ref_pls[c] = 1'b1; else fb_pls[c] = 1'b1;
            tick();
            ref_pls = '0; fb_pls = '0;
            for (int k = 1; k <= d; k++) begin
                chk($sformatf("R2 R3 R5 up c%0d p%0d h%0d l%0d", c, p, h, lead), {7'd0, pump_up[c]}, {7'd0, exp_up});
                chk($sformatf("R2 R3 R5 dn c%0d p%0d h%0d l%0d", c, p, h, lead), {7'd0, pump_dn[c]}, {7'd0, exp_dn});
                chk("R5 hiz flag", {7'd0, pump_hiz[c]}, {7'd0, !(exp_up | exp_dn)});
                chk("R2 other channel quiet", {7'd0, pump_hiz[1-c]}, 8'd1);
                if (k == d) begin
                    if (lead == 0) fb_pls[c] = 1'b1; else ref_pls[c] = 1'b1;
                end
                tick();
                ref_pls = '0; fb_pls = '0;
            end
            chk("R4 both recorded", {6'd0, pump_up[c], pump_dn[c]}, 8'd0);
            tick();
            chk("R4 both cleared", {6'd0, pump_up[c], pump_dn[c]}, 8'd0);
            pair(c);
            chk("R4 coincident", {6'd0, pump_up[c], pump_dn[c]}, 8'd0);
            tick();
            chk("R4 coincident next", {6'd0, pump_up[c], pump_dn[c]}, 8'd0);
        end
        pol_norm = 2'b11; hold_hiz = '0;

        // R7 R8 on channel 1 (index 0), after a power-down to restart count
        chan_pd = 2'b11; tick(); chan_pd = 2'b00; tick();
        for (int n = 1; n <= REFS; n++) begin
            pair(0);
            chk($sformatf("R7 lock after pair %0d", n), {7'd0, lock[0]}, {7'd0, n >= REFS});
            idle(3);
        end
        ref_pls[0] = 1'b1; tick(); ref_pls = '0;
        for (int k = 1; k < WIN; k++) tick();
        fb_pls[0] = 1'b1; tick(); fb_pls = '0;
        chk("R7 narrow error keeps lock", {7'd0, lock[0]}, 8'd1);
        idle(2);
        ref_pls[0] = 1'b1; tick(); ref_pls = '0;
        for (int k = 1; k <= WIN; k++) tick();
        chk("R8 lock before wide edge", {7'd0, lock[0]}, 8'd1);
        tick();
        chk("R8 wide error clears lock", {7'd0, lock[0]}, 8'd0);
        fb_pls[0] = 1'b1; tick(); idle(2);
        for (int n = 1; n <= REFS; n++) begin pair(0); idle(2); end
        chk("R7 relock", {7'd0, lock[0]}, 8'd1);
        fb_pls[0] = 1'b1; tick(); fb_pls = '0;
        for (int k = 1; k <= WIN; k++) tick();
        ref_pls[0] = 1'b1; tick(); ref_pls = '0;
        chk("R8 clear wins over ref", {7'd0, lock[0]}, 8'd0);
        idle(2);
        for (int n = 1; n <= REFS; n++) begin
            pair(0);
            chk($sformatf("R8 recount %0d", n), {7'd0, lock[0]}, {7'd0, n >= REFS});
            idle(2);
        end
        for (int n = 1; n <= REFS; n++) begin pair(1); idle(2); end
        chk("R7 channel 2 lock", {7'd0, lock[1]}, 8'd1);

        // R9: pin selection over lock patterns 00, 10, 11 of power-down
        for (int pat = 0; pat < 3; pat++) begin
            chan_pd = (pat == 0) ? 2'b00 : (pat == 1) ? 2'b01 : 2'b11;
            for (int s = 0; s < 4; s++)
            for (int pb = 0; pb < 2; pb++) begin
                logic l0, l1, e;
                l0 = !chan_pd[0]; l1 = !chan_pd[1];
                lock_sel = s[1:0]; port_bit = pb[0];
                e = (s == 0) ? pb[0] : (s == 1) ? l1 : (s == 2) ? l0 : (l0 | l1);
                tick();
                chk($sformatf("R9 pin sel%0d pd%0d pb%0d", s, chan_pd, pb), {7'd0, stat_pin}, {7'd0, e});
                chk("R9 lock port", {6'd0, lock}, {6'd0, l1, l0});
            end
        end

        // R6: pending lead is dropped by power-down
        chan_pd = 2'b00; lock_sel = 2'b00; idle(2);
        ref_pls[0] = 1'b1; tick(); ref_pls = '0;
        chk("R6 lead active", {7'd0, pump_dn[0]}, 8'd1);
        chan_pd[0] = 1'b1; #1;
        chk("R6 hiz at power-down", {7'd0, pump_hiz[0]}, 8'd1);
        chk("R6 no lock at power-down", {7'd0, lock[0]}, 8'd0);
        tick(); chan_pd[0] = 1'b0; tick();
        chk("R6 lead cleared", {6'd0, pump_up[0], pump_dn[0]}, 8'd0);

        // R10: counter test routing, all pulse patterns
        chan_pd = 2'b11; test_en = 1'b1;
        for (int s = 0; s < 4; s++)
        for (int pk = 0; pk < 2; pk++)
        for (int pat = 0; pat < 16; pat++) begin
            logic e;
            lock_sel = s[1:0]; pick_ref = {pk[0], pk[0]};
            port_bit = pat[0] ^ pk[0];
            ref_pls = {pat[2], pat[0]}; fb_pls = {pat[3], pat[1]};
            e = (s == 0) ? (pat[0] ^ pk[0]) :
                (s == 1) ? (pk[0] ? pat[2] : pat[3]) :
                (s == 2) ? (pk[0] ? pat[0] : pat[1]) : 1'b0;
            tick();
            ref_pls = '0; fb_pls = '0;
            chk($sformatf("R10 test sel%0d pick%0d pat%0d", s, pk, pat), {7'd0, stat_pin}, {7'd0, e});
        end

        done = 1;
        summary();
        $finish;
    end
endmodule